// File: doc/BRIEF.md
# Addressed Mailbox Store

This block takes address words and data words that arrive on two separate serial lines. Both lines share one transfer clock, which has no relation to the local clock. Each line has its own valid strobe. The block rebuilds each stream into a parallel word. It pairs every completed data word with the most recently completed address word. It then moves the pair into the local clock domain and writes the data into a fixed slot of a dual-port memory. The slot is chosen by the address, so every producer value has its own mailbox, and words may arrive in any order.

A local reader scans the memory on its own schedule through a simple read port. The reader can read a slot in the same cycle that a write lands on it. In that case the result is defined: the read returns the slot's previous contents, and the write is held back by one cycle, so no data is lost. A pair whose address or data word has the wrong number of bits is dropped and reported on a one-cycle error output.

Top module: `mailbox_store`

## Requirements
- R1: After reset, `rd_valid`, `frame_err` and `rd_data` are all low.
- R2: While a strobe is high, serial bits are shifted in on each rising edge of `xfer_clk`, most significant bit first. A word is complete when its strobe falls. A complete 16-bit data word is stored in the slot given by the low 7 bits of the latest complete 8-bit address word.
- R3: A read request on a rising `clk` edge makes `rd_data` and `rd_valid` valid on the next rising edge. `rd_valid` is low after any edge without a request.
- R4: When a read and a write hit the same slot in the same cycle, the read returns the slot's previous contents. The write commits in the following cycle. Later reads return the new value, and no value other than the old or the new one is ever seen.
- R5: A data word with a bit count other than 16 writes nothing, leaves every slot unchanged, and raises `frame_err` for exactly one `clk` cycle.
- R6: A data word whose latest address word had a bit count other than 8, or that arrives before any address word since reset, is dropped in the same way as in R5.
- R7: Each accepted pair is written exactly once. A later pair to the same slot overwrites an earlier one.
- R8: Bit 7 of the address word (the first bit sent) has no effect on the chosen slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local (reader) clock |
| rst | input | 1 | Synchronous active-high reset, local domain |
| xfer_clk | input | 1 | Serial transfer clock |
| xfer_rst | input | 1 | Synchronous active-high reset, transfer domain |
| addr_ser | input | 1 | Serial address line |
| addr_vld | input | 1 | Address strobe, high while address bits are sent |
| data_ser | input | 1 | Serial data line |
| data_vld | input | 1 | Data strobe, high while data bits are sent |
| rd_en | input | 1 | Read request |
| rd_addr | input | 7 | Slot to read |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | High when `rd_data` answers a request made on the previous edge |
| frame_err | output | 1 | One-cycle pulse when a pair is dropped |

## Verification
The hardest case to reach from the ports is the same-cycle collision, because the local cycle in which a write lands depends on the synchronizer and on the phase between the two unrelated clocks. The bench does not try to predict that cycle. Instead it reads the target slot on every cycle while a new word is being sent, which forces the write to collide. It then requires that the read sequence moves from old to new exactly once, never reverts and never shows any other value. Every slot is also swept with an arithmetic pattern, and framing faults are injected in both streams.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int DATA_BITS = 16;
  localparam int ADDR_BITS = 8;
  localparam int SLOT_COUNT = 128;
endpackage

// File: rtl/mbx_deser.sv
`timescale 1ns/1ps
// Serial-to-parallel converter framed by a valid strobe.
module mbx_deser #(
  parameter int NBITS = 16,
  parameter int KEEP  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser,
  input  logic            vld,
  output logic [KEEP-1:0] word,
  output logic            ok,
  output logic            done
);
  localparam int CW = $clog2(NBITS + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CEXP = CW'(NBITS);

  logic [KEEP-1:0] sh;
  logic [CW-1:0]   cnt;
  logic            vld_q;
  logic            fall;

  assign fall = vld_q && !vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      cnt   <= '0;
      vld_q <= 1'b0;
      done  <= 1'b0;
      word  <= '0;
      ok    <= 1'b0;
    end else begin
      vld_q <= vld;
      done  <= fall;
      if (vld) begin
        sh  <= {sh[KEEP-2:0], ser};
        cnt <= !vld_q ? CW'(1) : (cnt == CMAX ? cnt : cnt + 1'b1);
      end
      if (fall) begin
        word <= sh;
        ok   <= (cnt == CEXP);
      end
    end
  end

  // R2
  done_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!vld_q && $past(vld_q)));
endmodule

// File: rtl/mbx_cdc.sv
`timescale 1ns/1ps
// Toggle handshake carrying one record across clock domains.
module mbx_cdc #(
  parameter int W = 24
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic         launch,
  input  logic [W-1:0] src_pkt,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic         arrive,
  output logic [W-1:0] dst_pkt
);
  logic         tgl;
  logic [W-1:0] hold;
  logic [2:0]   sync;

  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      tgl  <= 1'b0;
      hold <= '0;
    end else if (launch) begin
      tgl  <= ~tgl;
      hold <= src_pkt;
    end
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) sync <= '0;
    else         sync <= {sync[1:0], tgl};
  end

  assign arrive  = sync[2] ^ sync[1];
  assign dst_pkt = hold;

  // R7
  single_arrival_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    arrive |=> !arrive);
endmodule

// File: rtl/mbx_ram.sv
`timescale 1ns/1ps
// Simple dual-port store, read-first, registered read.
module mbx_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= mem[raddr];
    end
  end

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid);
  // R3
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> !rvalid);
endmodule

// File: rtl/mailbox_store.sv
`timescale 1ns/1ps
module mailbox_store
  import mbx_pkg::*;
#(
  parameter int DATA_W = DATA_BITS,
  parameter int ADDR_W = ADDR_BITS,
  parameter int SLOTS  = SLOT_COUNT,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PKT_W  = 1 + SLOT_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_clk,
  input  logic              xfer_rst,
  input  logic              addr_ser,
  input  logic              addr_vld,
  input  logic              data_ser,
  input  logic              data_vld,
  input  logic              rd_en,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              frame_err
);
  // transfer domain
  logic [SLOT_W-1:0] a_word;
  logic              a_ok, a_done;
  logic [DATA_W-1:0] d_word;
  logic              d_ok, d_done;
  logic [PKT_W-1:0]  tx_pkt;

  mbx_deser #(.NBITS(ADDR_W), .KEEP(SLOT_W)) u_addr (
    .clk(xfer_clk), .rst(xfer_rst), .ser(addr_ser), .vld(addr_vld),
    .word(a_word), .ok(a_ok), .done(a_done));

  mbx_deser #(.NBITS(DATA_W), .KEEP(DATA_W)) u_data (
    .clk(xfer_clk), .rst(xfer_rst), .ser(data_ser), .vld(data_vld),
    .word(d_word), .ok(d_ok), .done(d_done));

  assign tx_pkt = {!(a_ok && d_ok), a_word, d_word};

  // local domain
  logic              arrive;
  logic [PKT_W-1:0]  rx_pkt;
  logic              rx_err;
  logic [SLOT_W-1:0] rx_slot;
  logic [DATA_W-1:0] rx_data;

  mbx_cdc #(.W(PKT_W)) u_cdc (
    .src_clk(xfer_clk), .src_rst(xfer_rst), .launch(d_done), .src_pkt(tx_pkt),
    .dst_clk(clk), .dst_rst(rst), .arrive(arrive), .dst_pkt(rx_pkt));

  assign {rx_err, rx_slot, rx_data} = rx_pkt;

  logic              wr_pend, wr_def, clash, wr_commit;
  logic [SLOT_W-1:0] wr_a;
  logic [DATA_W-1:0] wr_d;

  assign clash     = rd_en && (rd_addr == wr_a);
  assign wr_commit = wr_pend && (!clash || wr_def);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend   <= 1'b0;
      wr_def    <= 1'b0;
      wr_a      <= '0;
      wr_d      <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= arrive && rx_err;
      if (arrive && !rx_err) begin
        wr_pend <= 1'b1;
        wr_def  <= 1'b0;
        wr_a    <= rx_slot;
        wr_d    <= rx_data;
      end else if (wr_commit) begin
        wr_pend <= 1'b0;
        wr_def  <= 1'b0;
      end else if (wr_pend) begin
        wr_def  <= 1'b1;
      end
    end
  end

  mbx_ram #(.DW(DATA_W), .DEPTH(SLOTS)) u_ram (
    .clk(clk), .rst(rst), .we(wr_commit), .waddr(wr_a), .wdata(wr_d),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data), .rvalid(rd_valid));

  // R4
  deferred_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && !wr_commit && !arrive) |=> wr_commit);
  // R5
  err_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (arrive && rx_err && !wr_pend) |=> (frame_err && !wr_pend));
  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);
endmodule

// File: tb/test_mailbox_store.sv
`timescale 1ns/1ps
module test_mailbox_store;
  localparam int SLOTS = 128;

  logic clk = 1'b0, xclk = 1'b0;
  logic rst = 1'b1, xrst = 1'b1;
  logic addr_ser = 1'b0, addr_vld = 1'b0, data_ser = 1'b0, data_vld = 1'b0;
  logic rd_en = 1'b0;
  logic [6:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_valid, frame_err;

  int checks = 0, errors = 0, ferr_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always #85 xclk = ~xclk;

  mailbox_store i_mailbox_store (
    .clk(clk), .rst(rst), .xfer_clk(xclk), .xfer_rst(xrst),
    .addr_ser(addr_ser), .addr_vld(addr_vld), .data_ser(data_ser), .data_vld(data_vld),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .frame_err(frame_err));

  always @(negedge clk) if (!rst && frame_err) ferr_cnt++;

  function automatic logic [15:0] pat(int s);
    return 16'((s * 515 + 4369) & 16'hFFFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_out(int n, logic [31:0] v, bit is_addr);
    for (int i = 0; i < n; i++) begin
      @(negedge xclk);
      if (is_addr) begin addr_vld = 1'b1; addr_ser = v[n-1-i]; end
      else         begin data_vld = 1'b1; data_ser = v[n-1-i]; end
    end
    @(negedge xclk);
    addr_vld = 1'b0; data_vld = 1'b0;
  endtask

  task automatic send_pair(int an, logic [31:0] a, int dn, logic [31:0] d);
    if (an > 0) shift_out(an, a, 1'b1);
    shift_out(dn, d, 1'b0);
    repeat (3) @(negedge xclk);
    repeat (6) @(negedge clk);
  endtask

  task automatic rd(int s, output logic [15:0] v, output logic ok);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 7'(s);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data; ok = rd_valid;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic ok;
    int base;
    repeat (8) @(negedge xclk);
    @(negedge clk); rst = 1'b0; xrst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 rd_data", rd_data, 0);

    // R6 data with no address since reset
    base = ferr_cnt;
    send_pair(0, 0, 16, 16'h1234);
    chk("R6 no address", ferr_cnt, base + 1);

    // R2 sweep every slot
    for (int s = 0; s < SLOTS; s++) send_pair(8, s, 16, pat(s));
    for (int s = 0; s < SLOTS; s++) begin
      rd(s, v, ok);
      chk("R2 sweep data", v, pat(s));
      if (s == 0) chk("R3 rd_valid", ok, 1);
    end
    @(negedge clk);
    chk("R3 idle rd_valid", rd_valid, 0);
    chk("R2 no spurious errors", ferr_cnt, base + 1);

    // R5 short and long data words
    send_pair(8, 3, 15, 32'h0000_5EAD);
    chk("R5 short data flag", ferr_cnt, base + 2);
    rd(3, v, ok); chk("R5 short data slot", v, pat(3));
    send_pair(8, 3, 17, 32'h0001_BEEF);
    chk("R5 long data flag", ferr_cnt, base + 3);
    rd(3, v, ok); chk("R5 long data slot", v, pat(3));

    // R6 bad address count
    send_pair(7, 4, 16, 16'hCAFE);
    chk("R6 short addr flag", ferr_cnt, base + 4);
    rd(4, v, ok); chk("R6 short addr slot", v, pat(4));
    send_pair(9, 4, 16, 16'hCAFE);
    chk("R6 long addr flag", ferr_cnt, base + 5);
    rd(4, v, ok); chk("R6 long addr slot", v, pat(4));

    // R8 top address bit ignored
    send_pair(8, 32'h80 | 9, 16, 16'h0F0F);
    rd(9, v, ok); chk("R8 high bit ignored", v, 16'h0F0F);

    // R7 later write wins
    send_pair(8, 20, 16, 16'hAAAA);
    send_pair(8, 20, 16, 16'h5555);
    rd(20, v, ok); chk("R7 overwrite", v, 16'h5555);
    rd(21, v, ok); chk("R7 neighbour untouched", v, pat(21));

    // R4 collision: read the slot every cycle while a write lands
    begin
      int bad = 0, flips = 0;
      bit seen_new = 1'b0;
      fork
        send_pair(8, 5, 16, 16'h5A5A);
        begin
          @(negedge clk);
          rd_en = 1'b1; rd_addr = 7'd5;
          repeat (300) begin
            @(negedge clk);
            if (rd_data === 16'h5A5A) begin
              if (!seen_new) flips++;
              seen_new = 1'b1;
            end else if (rd_data === pat(5)) begin
              if (seen_new) bad++;
            end else bad++;
          end
          rd_en = 1'b0;
        end
      join
      chk("R4 no torn or reverted value", bad, 0);
      chk("R4 single transition", flips, 1);
      rd(5, v, ok); chk("R4 write not lost", v, 16'h5A5A);
    end
    chk("R5 total error pulses", ferr_cnt, base + 5);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule